// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table from memory. A requester hands over one virtual address and a read/write flag through a valid/ready handshake. The walker first checks that the virtual page number lies under a programmed page limit. If it does not, the walker answers at once with an illegal-reference fault and touches no memory. Otherwise it reads the outer-level entry at the table base, then the inner-level (leaf) entry in the table that the outer entry points to. It answers with the frame number joined to the untouched 12-bit offset, or with a page fault.

Each entry is one 32-bit word. The frame number sits in bits [31:12], bit 0 is the valid flag, bit 1 is the referenced flag and bit 2 is the modified flag. Bits [11:3] are carried through unchanged. On a successful walk the walker sets the referenced flag in the leaf, and on a write it also sets the modified flag. The updated word goes back to memory in a single write, and only if one of the two flags actually changes. The table base and the page limit are loaded together through a configuration strobe, which is meant to be used while no walk is in progress. Only one walk is in flight at any time.

The controller is a single state machine with these states:
- IDLE accepts a request. An out-of-range request goes straight to RESP; any other request goes to OUT_REQ.
- OUT_REQ issues the outer read and moves to OUT_WAIT once the memory port accepts it.
- OUT_WAIT waits for the read data. An invalid outer entry goes to RESP with a page fault; a valid one goes to IN_REQ.
- IN_REQ issues the leaf read and moves to IN_WAIT once the memory port accepts it.
- IN_WAIT latches the leaf entry when the data returns and moves to LEAF.
- LEAF decides the outcome. An invalid leaf goes to RESP with a page fault. A leaf whose flags need changing goes to WB. Any other leaf goes to RESP.
- WB writes the updated leaf back and moves to RESP once the write is accepted.
- RESP holds the answer and returns to IDLE when the requester takes it.

Top module: `pgw_walker`

## Requirements
- R1: On a successful walk, rsp_fault is 0 and rsp_paddr equals the leaf frame number (entry bits [31:12]) followed by virtual address bits [11:0].
- R2: If the virtual page number (vaddr[31:12]) is greater than or equal to the configured limit, the response carries fault code 1 (illegal reference) and no memory request is issued; a page number of limit-1 is not flagged illegal.
- R3: A legal walk first reads address base + 4*vaddr[31:22]. If that entry is valid, it then reads address {outer entry bits [31:12], 12'h000} + 4*vaddr[21:12]. A request held without mem_ready keeps its address.
- R4: If the outer entry's valid bit (bit 0) is 0, the response carries fault code 2 (page fault) after exactly one memory read and no write.
- R5: If the leaf entry's valid bit is 0, the response carries fault code 2 after two reads, and the leaf is not written.
- R6: On a successful read walk whose leaf has the referenced flag (bit 1) clear, exactly one write goes to the leaf address. Its data is the old leaf with bit 1 set and every other bit kept.
- R7: On a successful write walk, the leaf written back has both bit 1 and the modified flag (bit 2) set, with all other bits kept.
- R8: When the leaf already holds every flag the access would set, no write-back is issued.
- R9: After reset, and while a walk is in progress, req_ready is 1 only when no walk is in progress. rsp_valid, rsp_paddr and rsp_fault hold steady until rsp_ready is seen. rsp_valid drops after the handshake.
- R10: A cfg_we pulse loads a new table base and page limit, and every later walk uses them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the base and limit clear to 0 |
| cfg_we | input | 1 | Load strobe for the base and the limit |
| cfg_base | input | 32 | Byte address of the outer table |
| cfg_limit | input | 21 | Page numbers at or above this value are illegal |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 2 | 0 none, 1 illegal reference, 2 page fault |
| mem_req | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Updated leaf entry for a write |
| mem_rvalid | input | 1 | Read data valid, at any time after the read is accepted |
| mem_rdata | input | 32 | Read data |

## Verification
The bench builds the walker with its default split: 10 outer bits, 10 inner bits, a 12-bit offset and a 20-bit frame. Addresses and entries are therefore full 32-bit words, and the limit check can be pushed right up to the boundary between page 4095 and page 4096. With this split, a table base, an outer table and a leaf table can all be placed at separate, easy-to-read addresses in a sparse memory model. The model can also stall requests on alternate cycles, which exercises the hold rules on both the memory side and the response side.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    // Response codes on rsp_fault.
    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ILLEGAL = 2'd1,
        FLT_PAGE    = 2'd2
    } fault_e;

    // Flag positions inside a table entry.
    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_REF_BIT   = 1;
    localparam int PTE_MOD_BIT   = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OUT_REQ,
        S_OUT_WAIT,
        S_IN_REQ,
        S_IN_WAIT,
        S_LEAF,
        S_WB,
        S_RESP
    } walk_state_e;

endpackage

// File: rtl/pgw_range_check.sv
module pgw_range_check #(
    parameter int VPN_W = 20
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [VPN_W:0]   limit,
    output logic             illegal
);
    // Compare one bit wider so that a limit of 2**VPN_W permits every page.
    always_comb begin
        illegal = ({1'b0, vpn} >= limit);
    end

endmodule

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
    parameter int OUT_W   = 10,
    parameter int IN_W    = 10,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 20,
    parameter int ENT_SH  = 2,
    localparam int PA_W   = FRAME_W + OFF_W
) (
    input  logic [PA_W-1:0]    table_base,
    input  logic [OUT_W-1:0]   outer_idx,
    input  logic [IN_W-1:0]    inner_idx,
    input  logic [FRAME_W-1:0] inner_frame,
    output logic [PA_W-1:0]    outer_addr,
    output logic [PA_W-1:0]    inner_addr
);
    localparam int OUT_PAD = PA_W - OUT_W - ENT_SH;
    localparam int IN_PAD  = PA_W - IN_W - ENT_SH;

    logic [PA_W-1:0] outer_off;
    logic [PA_W-1:0] inner_off;

    always_comb begin
        outer_off  = {{OUT_PAD{1'b0}}, outer_idx, {ENT_SH{1'b0}}};
        inner_off  = {{IN_PAD{1'b0}}, inner_idx, {ENT_SH{1'b0}}};
        outer_addr = table_base + outer_off;
        inner_addr = {inner_frame, {OFF_W{1'b0}}} + inner_off;
    end

endmodule

// File: rtl/pgw_pte_update.sv
module pgw_pte_update #(
    parameter int PTE_W = 32
) (
    input  logic [PTE_W-1:0] pte_in,
    input  logic             is_write,
    output logic [PTE_W-1:0] pte_out,
    output logic             changed
);
    import pgw_pkg::*;

    logic [PTE_W-1:0] set_mask;

    always_comb begin
        set_mask                = '0;
        set_mask[PTE_REF_BIT]   = 1'b1;
        set_mask[PTE_MOD_BIT]   = is_write;
        pte_out                 = pte_in | set_mask;
        changed                 = (pte_out != pte_in);
    end

endmodule

// File: rtl/pgw_walker.sv
module pgw_walker #(
    parameter int OUT_W   = 10,
    parameter int IN_W    = 10,
    parameter int OFF_W   = 12,
    parameter int FRAME_W = 20,
    localparam int VPN_W  = OUT_W + IN_W,
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = FRAME_W + OFF_W,
    localparam int PTE_W  = PA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [PA_W-1:0]  cfg_base,
    input  logic [VPN_W:0]   cfg_limit,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault,
    output logic             mem_req,
    input  logic             mem_ready,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata
);
    import pgw_pkg::*;

    localparam int ENT_SH = $clog2(PTE_W / 8);

    walk_state_e state, state_nx;

    logic [PA_W-1:0]  base_q;
    logic [VPN_W:0]   limit_q;
    logic [VA_W-1:0]  va_q;
    logic             wr_q;
    logic [PTE_W-1:0] outer_q;
    logic [PTE_W-1:0] leaf_q;
    logic [PA_W-1:0]  paddr_q;
    fault_e           fault_q;

    logic             req_illegal;
    logic [PA_W-1:0]  outer_addr;
    logic [PA_W-1:0]  inner_addr;
    logic [PTE_W-1:0] leaf_new;
    logic             leaf_changed;

    pgw_range_check #(.VPN_W(VPN_W)) u_range (
        .vpn     (req_vaddr[VA_W-1:OFF_W]),
        .limit   (limit_q),
        .illegal (req_illegal)
    );

    pgw_addr_gen #(
        .OUT_W   (OUT_W),
        .IN_W    (IN_W),
        .OFF_W   (OFF_W),
        .FRAME_W (FRAME_W),
        .ENT_SH  (ENT_SH)
    ) u_addr (
        .table_base  (base_q),
        .outer_idx   (va_q[VA_W-1:VA_W-OUT_W]),
        .inner_idx   (va_q[OFF_W+IN_W-1:OFF_W]),
        .inner_frame (outer_q[PTE_W-1:OFF_W]),
        .outer_addr  (outer_addr),
        .inner_addr  (inner_addr)
    );

    pgw_pte_update #(.PTE_W(PTE_W)) u_update (
        .pte_in   (leaf_q),
        .is_write (wr_q),
        .pte_out  (leaf_new),
        .changed  (leaf_changed)
    );

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (req_valid) state_nx = req_illegal ? S_RESP : S_OUT_REQ;
            S_OUT_REQ:  if (mem_ready) state_nx = S_OUT_WAIT;
            S_OUT_WAIT: if (mem_rvalid)
                            state_nx = mem_rdata[PTE_VALID_BIT] ? S_IN_REQ : S_RESP;
            S_IN_REQ:   if (mem_ready) state_nx = S_IN_WAIT;
            S_IN_WAIT:  if (mem_rvalid) state_nx = S_LEAF;
            S_LEAF: begin
                if (!leaf_q[PTE_VALID_BIT]) state_nx = S_RESP;
                else if (leaf_changed)      state_nx = S_WB;
                else                        state_nx = S_RESP;
            end
            S_WB:       if (mem_ready) state_nx = S_RESP;
            S_RESP:     if (rsp_ready) state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Walk datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            limit_q <= '0;
            va_q    <= '0;
            wr_q    <= 1'b0;
            outer_q <= '0;
            leaf_q  <= '0;
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else begin
            if (cfg_we) begin
                base_q  <= cfg_base;
                limit_q <= cfg_limit;
            end
            unique case (state)
                S_IDLE: if (req_valid) begin
                    va_q    <= req_vaddr;
                    wr_q    <= req_write;
                    paddr_q <= '0;
                    fault_q <= req_illegal ? FLT_ILLEGAL : FLT_NONE;
                end
                S_OUT_WAIT: if (mem_rvalid) begin
                    outer_q <= mem_rdata;
                    if (!mem_rdata[PTE_VALID_BIT]) fault_q <= FLT_PAGE;
                end
                S_IN_WAIT: if (mem_rvalid) leaf_q <= mem_rdata;
                S_LEAF: begin
                    if (!leaf_q[PTE_VALID_BIT]) fault_q <= FLT_PAGE;
                    else paddr_q <= {leaf_q[PTE_W-1:OFF_W], va_q[OFF_W-1:0]};
                end
                default: ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = inner_addr;
        unique case (state)
            S_IDLE:    req_ready = 1'b1;
            S_OUT_REQ: begin
                mem_req  = 1'b1;
                mem_addr = outer_addr;
            end
            S_IN_REQ:  mem_req = 1'b1;
            S_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_RESP:    rsp_valid = 1'b1;
            default: ;
        endcase
    end

    assign mem_wdata = leaf_new;
    assign rsp_paddr = paddr_q;
    assign rsp_fault = fault_q;

    // Response stays put until it is taken.
    assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

    // A single walk in flight: no new request is accepted while a response is pending.
    assert_one_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // Offset bits pass straight through on success.
    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_NONE) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

    // An illegal reference is answered straight from IDLE with no memory traffic.
    assert_illegal_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rsp_valid) && rsp_fault == FLT_ILLEGAL) |-> ($past(state) == S_IDLE));

    // A stalled memory request keeps its address and kind.
    assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // A write-back only targets a valid leaf.
    assert_wb_valid_leaf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> leaf_q[PTE_VALID_BIT]);

    // A write-back always changes the leaf.
    assert_wb_changes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata != leaf_q));

endmodule

// File: tb/pgw_walker_test.sv
module pgw_walker_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [20:0] cfg_limit = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req;
    logic        mem_ready;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgw_walker uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Sparse memory model with optional alternate-cycle stalls.
    logic [31:0] mem [logic [31:0]];
    logic        stall_en = 1'b0;
    logic        tick = 1'b0;
    int          n_rd = 0;
    int          n_wr = 0;
    logic [31:0] rd_log [0:255];
    logic [31:0] last_wa = '0;
    logic [31:0] last_wd = '0;

    assign mem_ready = !stall_en || tick;

    function automatic logic [31:0] peek(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        tick       <= ~tick;
        mem_rvalid <= 1'b0;
        if (mem_req && mem_ready) begin
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                last_wa <= mem_addr;
                last_wd <= mem_wdata;
                n_wr    <= n_wr + 1;
            end else begin
                mem_rvalid      <= 1'b1;
                mem_rdata       <= peek(mem_addr);
                rd_log[n_rd[7:0]] <= mem_addr;
                n_rd            <= n_rd + 1;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic configure(input logic [31:0] base, input logic [20:0] limit);
        @(negedge clk);
        cfg_we = 1'b1; cfg_base = base; cfg_limit = limit;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Results of the last walk.
    logic [31:0] w_paddr;
    logic [1:0]  w_fault;
    int          w_rd, w_wr, w_rd0;

    task automatic walk(input logic [31:0] va, input bit wr, input int hold);
        int rd0, wr0;
        bit rdy;
        logic [31:0] p0;
        logic [1:0]  f0;
        @(negedge clk);
        rd0 = n_rd; wr0 = n_wr;
        req_vaddr = va; req_write = wr; req_valid = 1'b1;
        forever begin
            rdy = req_ready;
            @(negedge clk);
            if (rdy) break;
        end
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        p0 = rsp_paddr; f0 = rsp_fault;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(rsp_valid == 1'b1, "R9", "rsp_valid held", {31'b0, rsp_valid}, 32'h1);
            chk(rsp_paddr == p0 && rsp_fault == f0, "R9", "response stable", rsp_paddr, p0);
            chk(req_ready == 1'b0, "R9", "req_ready low while busy", {31'b0, req_ready}, 32'h0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(rsp_valid == 1'b0, "R9", "rsp_valid drops after handshake", {31'b0, rsp_valid}, 32'h0);
        chk(req_ready == 1'b1, "R9", "ready again after handshake", {31'b0, req_ready}, 32'h1);
        w_paddr = p0; w_fault = f0;
        w_rd = n_rd - rd0; w_wr = n_wr - wr0; w_rd0 = rd0;
    endtask

    localparam logic [31:0] VA_A = 32'h0040_5ABC;   // outer 1, inner 5, offset ABC

    task automatic t_reset();
        chk(req_ready == 1'b1, "R9", "reset req_ready", {31'b0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R9", "reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
        chk(mem_req == 1'b0, "R9", "reset mem_req", {31'b0, mem_req}, 32'h0);
    endtask

    task automatic t_first_read();
        walk(VA_A, 1'b0, 0);
        chk(w_fault == 2'd0, "R1", "fault on good read", {30'b0, w_fault}, 32'h0);
        chk(w_paddr == 32'h1234_5ABC, "R1", "paddr", w_paddr, 32'h1234_5ABC);
        chk(w_rd == 2, "R3", "read count", w_rd, 2);
        chk(rd_log[w_rd0[7:0]] == 32'h0001_0004, "R3", "outer addr", rd_log[w_rd0[7:0]], 32'h0001_0004);
        chk(rd_log[w_rd0[7:0]+8'd1] == 32'h0002_0014, "R3", "inner addr", rd_log[w_rd0[7:0]+8'd1], 32'h0002_0014);
        chk(w_wr == 1, "R6", "write-back count", w_wr, 1);
        chk(last_wa == 32'h0002_0014, "R6", "write-back addr", last_wa, 32'h0002_0014);
        chk(last_wd == 32'h1234_50F3, "R6", "write-back data", last_wd, 32'h1234_50F3);
    endtask

    task automatic t_repeat_read();
        walk(VA_A, 1'b0, 0);
        chk(w_paddr == 32'h1234_5ABC && w_fault == 2'd0, "R1", "repeat paddr", w_paddr, 32'h1234_5ABC);
        chk(w_wr == 0, "R8", "no write-back when referenced", w_wr, 0);
    endtask

    task automatic t_first_write();
        walk(32'h0040_5004, 1'b1, 0);
        chk(w_paddr == 32'h1234_5004 && w_fault == 2'd0, "R1", "write paddr", w_paddr, 32'h1234_5004);
        chk(w_wr == 1, "R7", "write sets modified", w_wr, 1);
        chk(peek(32'h0002_0014) == 32'h1234_50F7, "R7", "leaf after write", peek(32'h0002_0014), 32'h1234_50F7);
    endtask

    task automatic t_repeat_write();
        walk(32'h0040_5FFF, 1'b1, 0);
        chk(w_paddr == 32'h1234_5FFF, "R1", "top offset", w_paddr, 32'h1234_5FFF);
        chk(w_wr == 0, "R8", "no write-back when modified", w_wr, 0);
    endtask

    task automatic t_illegal();
        walk(32'h0100_0000, 1'b0, 0);
        chk(w_fault == 2'd1, "R2", "illegal fault code", {30'b0, w_fault}, 32'h1);
        chk(w_rd == 0 && w_wr == 0, "R2", "no memory traffic", w_rd + w_wr, 0);
    endtask

    task automatic t_outer_invalid();
        walk(32'h00FF_F000, 1'b0, 0);     // page 4095: legal, outer entry empty
        chk(w_fault == 2'd2, "R4", "outer invalid fault", {30'b0, w_fault}, 32'h2);
        chk(w_rd == 1 && w_wr == 0, "R4", "single read", w_rd, 1);
        chk(rd_log[w_rd0[7:0]] == 32'h0001_000C, "R3", "outer addr idx3", rd_log[w_rd0[7:0]], 32'h0001_000C);
    endtask

    task automatic t_leaf_invalid();
        walk(32'h0040_6123, 1'b1, 0);
        chk(w_fault == 2'd2, "R5", "leaf invalid fault", {30'b0, w_fault}, 32'h2);
        chk(w_paddr == 32'h0, "R5", "no paddr on fault", w_paddr, 32'h0);
        chk(w_rd == 2 && w_wr == 0, "R5", "two reads no write", w_wr, 0);
        chk(peek(32'h0002_0018) == 32'h5555_50F0, "R5", "leaf untouched", peek(32'h0002_0018), 32'h5555_50F0);
    endtask

    task automatic t_backpressure();
        stall_en = 1'b1;
        walk(VA_A, 1'b0, 4);
        stall_en = 1'b0;
        chk(w_paddr == 32'h1234_5ABC, "R3", "stalled walk paddr", w_paddr, 32'h1234_5ABC);
        chk(w_rd == 2, "R3", "stalled walk reads", w_rd, 2);
    endtask

    task automatic t_reconfig();
        configure(32'h0003_0000, 21'd1029);
        walk(VA_A, 1'b0, 0);
        chk(w_fault == 2'd1, "R10", "new limit applied", {30'b0, w_fault}, 32'h1);
        configure(32'h0003_0000, 21'd1030);
        walk(VA_A, 1'b0, 0);
        chk(w_fault == 2'd0 && w_paddr == 32'hABCD_EABC, "R10", "new base paddr", w_paddr, 32'hABCD_EABC);
        chk(rd_log[w_rd0[7:0]] == 32'h0003_0004, "R10", "outer from new base", rd_log[w_rd0[7:0]], 32'h0003_0004);
        chk(rd_log[w_rd0[7:0]+8'd1] == 32'h0004_0014, "R3", "inner in new table", rd_log[w_rd0[7:0]+8'd1], 32'h0004_0014);
        chk(w_wr == 0, "R8", "flags already set", w_wr, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        mem[32'h0001_0004] = 32'h0002_0001;   // outer 1 -> table at 0x20000
        mem[32'h0002_0014] = 32'h1234_50F1;   // leaf: valid, spare bits set
        mem[32'h0002_0018] = 32'h5555_50F0;   // leaf: invalid
        mem[32'h0003_0004] = 32'h0004_0001;
        mem[32'h0004_0014] = 32'hABCD_E007;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        configure(32'h0001_0000, 21'h1000);
        t_first_read();
        t_repeat_read();
        t_first_write();
        t_repeat_write();
        t_illegal();
        t_outer_invalid();
        t_leaf_invalid();
        t_backpressure();
        t_reconfig();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule